// File: doc/BRIEF.md
# Per-Line Programmable Input Debouncer

This block holds a bank of input filters, one for each external line. Each line passes through a two-stage synchroniser and then, if filtering is active for it, a stability counter. The registered output takes a new value only once the synchronised input has differed from it for an unbroken run of reference ticks. A shared prescaler turns the system clock into that tick, nominally one per microsecond. When filtering is not active for a line, its output follows the synchronised input.

Software programs each line through an 8-bit field. Four fields share one 32-bit word. Every word can be reached at three addresses:
- a plain address that reads the word and loads it,
- a set alias that ORs ones into it,
- a clear alias that removes ones from it.

A field carries an enable bit, a restart strobe and a 3-bit window code. Filtering is possible only on lines whose index is below a configured limit and only while the line's level-sensitivity input is high. The usual service sequence is this: after handling an event on a filtered line, software pulses that line's restart strobe.

Top module: `dbnc_bank`

## Requirements
- R1: Line n owns byte n%4 of word n/4. Word k sits at CTRL_OFF+4k for plain access (default 0x500), at SET_OFF+4k for the set alias (0x600) and at CLR_OFF+4k for the clear alias (0x700). A write to the plain address loads the field. In the field, bit 0 is the enable, bit 1 is the restart strobe and bits 6:4 are the window code; bits 2, 3 and 7 read 0.
- R2: A write to the set alias ORs the written enable and window-code bits into the field and leaves every other bit as it was.
- R3: A write to the clear alias clears every enable and window-code bit written as 1. Writing 0xFF to a line's byte empties that line's field.
- R4: The restart strobe always reads 0. Writing it as 1 through the plain or set address zeroes the line's stability count and holds it at zero for at least two further clock cycles.
- R5: Window codes 0 to 6 select 500, 1000, 16000, 32000, 64000, 128000 and 256000 ticks. Code 7 selects 256000.
- R6: On a filtered line, the output takes the synchronised input value after that value has differed from the output for the selected number of ticks without a break. A shorter excursion leaves the output unchanged.
- R7: When a line's enable is 0, or its level-sensitivity input is 0, or its index is at or above DBNC_LIMIT, its output equals the input delayed by three clock edges.
- R8: Fields of lines at or above DBNC_LIMIT read 0, and writes to them are ignored.
- R9: Synchronous reset clears every field, every output and the read data.
- R10: A read returns the addressed word on bus_rdata one clock edge after the address is presented. Any of the three aliases returns the plain word contents. Any other address returns 0.
- R11: The prescaler issues one tick every TICK_DIV clock cycles, so a window of W ticks spans about W*TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| level_sens | input | NUM_LINES | Per-line high when the line is level sensitive |
| line_in | input | NUM_LINES | Raw asynchronous inputs |
| line_out | output | NUM_LINES | Filtered, registered outputs |

## Verification
The assertions assume the following about the inputs:
- Writes are word aligned.
- Raw inputs are low while reset is held, so the three-edge input-to-output relation holds from the first post-reset cycles.
- A clear-alias write of all ones targets word 0 only when the check on word 0 is meant.

The stimulus meets these assumptions as follows:
- It changes inputs and bus signals only on falling clock edges.
- It keeps every line low through reset.
- It changes a line's input only after that line's field has been reprogrammed and read back.
- It leaves the lines with the longest windows undisturbed, so the run fits its cycle budget.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int FIELD_W = 8;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 18;

  function automatic logic [CNT_W-1:0] win_ticks(input logic [2:0] code);
    case (code)
      3'd0:    win_ticks = CNT_W'(500);
      3'd1:    win_ticks = CNT_W'(1000);
      3'd2:    win_ticks = CNT_W'(16000);
      3'd3:    win_ticks = CNT_W'(32000);
      3'd4:    win_ticks = CNT_W'(64000);
      3'd5:    win_ticks = CNT_W'(128000);
      default: win_ticks = CNT_W'(256000);
    endcase
  endfunction
endpackage

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q  <= '0;
          tick_o <= 1'b0;
        end else begin
          tick_o <= (pre_q == PW'(DIV - 2));
          if (pre_q == PW'(DIV - 1)) pre_q <= '0;
          else                       pre_q <= pre_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs #(
  parameter int              NUM_LINES  = 8,
  parameter int              DBNC_LIMIT = 6,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h500,
  parameter logic [ADDR_W-1:0] SET_OFF  = 12'h600,
  parameter logic [ADDR_W-1:0] CLR_OFF  = 12'h700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              en_o      [NUM_LINES],
  output logic [2:0]        code_o    [NUM_LINES],
  output logic              restart_o [NUM_LINES],
  output logic [31:0]       word0_o
);
  localparam int WORDS  = (NUM_LINES + 3) / 4;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * 4);

  function automatic logic in_win(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    in_win = (a[1:0] == 2'b00) && (a >= base) && (a < base + SPAN);
  endfunction

  logic hit_ctrl, hit_set, hit_clr, hit_any;
  logic [ADDR_W-1:0] rel;
  logic [WIDX_W-1:0] widx;

  always_comb begin
    hit_ctrl = in_win(bus_addr, CTRL_OFF);
    hit_set  = in_win(bus_addr, SET_OFF);
    hit_clr  = in_win(bus_addr, CLR_OFF);
    hit_any  = hit_ctrl | hit_set | hit_clr;
    if (hit_set)      rel = bus_addr - SET_OFF;
    else if (hit_clr) rel = bus_addr - CLR_OFF;
    else              rel = bus_addr - CTRL_OFF;
    widx = rel[WIDX_W+1:2];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int W = i / 4;
    localparam int B = (i % 4) * 8;
    if (i < DBNC_LIMIT) begin : g_act
      logic       en_q, pulse_q;
      logic [2:0] code_q;
      logic       here;
      assign here = bus_we && hit_any && (widx == WIDX_W'(W));
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q    <= 1'b0;
          code_q  <= 3'b000;
          pulse_q <= 1'b0;
        end else begin
          pulse_q <= 1'b0;
          if (here && hit_ctrl) begin
            en_q    <= bus_wdata[B];
            code_q  <= bus_wdata[B+6:B+4];
            pulse_q <= bus_wdata[B+1];
          end else if (here && hit_set) begin
            en_q    <= en_q | bus_wdata[B];
            code_q  <= code_q | bus_wdata[B+6:B+4];
            pulse_q <= bus_wdata[B+1];
          end else if (here && hit_clr) begin
            en_q    <= en_q & ~bus_wdata[B];
            code_q  <= code_q & ~bus_wdata[B+6:B+4];
          end
        end
      end
      assign en_o[i]      = en_q;
      assign code_o[i]    = code_q;
      assign restart_o[i] = pulse_q;
    end else begin : g_off
      assign en_o[i]      = 1'b0;
      assign code_o[i]    = 3'b000;
      assign restart_o[i] = 1'b0;
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    word0_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (hit_any && (i / 4 == int'(widx)))
        rd_word[(i % 4) * 8 +: 8] = {1'b0, code_o[i], 3'b000, en_o[i]};
      if (i < 4)
        word0_o[i * 8 +: 8] = {1'b0, code_o[i], 3'b000, en_o[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end
endmodule

// File: rtl/dbnc_line.sv
module dbnc_line
  import dbnc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       din,
  input  logic       active,
  input  logic [2:0] code,
  input  logic       restart,
  output logic       dout
);
  logic             s1_q, s2_q;
  logic [1:0]       hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = win_ticks(code) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      dout   <= 1'b0;
      hold_q <= 2'd0;
      cnt_q  <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      if (restart)            hold_q <= 2'd2;
      else if (hold_q != 2'd0) hold_q <= hold_q - 1'b1;

      if (!active) begin
        dout  <= s2_q;
        cnt_q <= '0;
      end else if (restart || hold_q != 2'd0 || s2_q == dout) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q >= limit) begin
          dout  <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbnc_bank.sv
module dbnc_bank #(
  parameter int              NUM_LINES  = 8,
  parameter int              DBNC_LIMIT = 6,
  parameter int              TICK_DIV   = 50,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h500,
  parameter logic [ADDR_W-1:0] SET_OFF  = 12'h600,
  parameter logic [ADDR_W-1:0] CLR_OFF  = 12'h700
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] level_sens,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] line_out
);
  logic        en     [NUM_LINES];
  logic [2:0]  code   [NUM_LINES];
  logic        restart[NUM_LINES];
  logic [31:0] ctrl_word0;
  logic        tick;

  dbnc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  dbnc_regs #(
    .NUM_LINES(NUM_LINES), .DBNC_LIMIT(DBNC_LIMIT), .ADDR_W(ADDR_W),
    .CTRL_OFF(CTRL_OFF), .SET_OFF(SET_OFF), .CLR_OFF(CLR_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_o(en),
    .code_o(code), .restart_o(restart), .word0_o(ctrl_word0)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
    dbnc_line u_line (
      .clk(clk), .rst(rst), .tick(tick), .din(line_in[i]),
      .active(en[i] & level_sens[i]), .code(code[i]),
      .restart(restart[i]), .dout(line_out[i])
    );
  end
endmodule

// File: rtl/dbnc_bank_chk.sv
module dbnc_bank_chk #(
  parameter int              N      = 8,
  parameter int              LIMIT  = 6,
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SET_A = 12'h600,
  parameter logic [ADDR_W-1:0] CLR_A = 12'h700
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N-1:0]      line_in,
  input logic [N-1:0]      line_out,
  input logic [31:0]       ctrl_word0
);
  localparam logic [31:0] STROBE_BITS = 32'h0202_0202;
  logic [2:0] up_q;

  always_ff @(posedge clk) begin
    if (rst)                up_q <= 3'd0;
    else if (up_q != 3'd7)  up_q <= up_q + 1'b1;
  end

  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & STROBE_BITS) == 32'h0); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == CLR_A && bus_wdata == 32'hFFFF_FFFF) |=> ctrl_word0 == 32'h0); // R3

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (up_q != 3'd0 && bus_we && bus_addr == SET_A) |=> (($past(ctrl_word0) & ~ctrl_word0) == 32'h0)); // R2

  for (genvar i = 0; i < N; i++) begin : g_a
    AST_OUT_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
      (up_q >= 3'd5 && line_out[i] != $past(line_out[i])) |-> line_out[i] == $past(line_in[i], 3)); // R6
    if (i >= LIMIT) begin : g_by
      AST_LIMIT_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (up_q >= 3'd5) |-> line_out[i] == $past(line_in[i], 3)); // R7
    end
  end
endmodule

bind dbnc_bank dbnc_bank_chk #(
  .N(NUM_LINES), .LIMIT(DBNC_LIMIT), .ADDR_W(ADDR_W), .SET_A(SET_OFF), .CLR_A(CLR_OFF)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .line_in(line_in), .line_out(line_out), .ctrl_word0(ctrl_word0)
);

// File: tb/tb_dbnc_bank.sv
module tb_dbnc_bank;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] level_sens = 8'b1111_0111;
  logic [N-1:0] line_in = '0;
  logic [N-1:0] line_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  typedef struct { int at; int line; logic val; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbnc_bank #(.NUM_LINES(N), .DBNC_LIMIT(6), .TICK_DIV(2)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_sens(level_sens),
    .line_in(line_in), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_out(input int dly, input int line, input logic v, input string tag);
    exp_t e;
    e.at = cyc + dly; e.line = line; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].at == cyc) begin
        chk(line_out[sb[k].line] === sb[k].val, sb[k].tag,
            32'(line_out[sb[k].line]), 32'(sb[k].val));
        sb.delete(k);
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    rd(12'h500, 32'h0, "R9 fields after reset");
    chk(line_out === 8'h00, "R9 outputs after reset", 32'(line_out), 32'h0);

    // R1 plain load: line0 en code0, line1 en code1
    wr(12'h500, 32'h0000_1101);
    rd(12'h500, 32'h0000_1101, "R1 plain load readback");
    // R2 set alias adds line3 enable
    wr(12'h600, 32'h0100_0000);
    rd(12'h500, 32'h0100_1101, "R2 set alias ORs");
    // R10 alias read and unmapped read
    rd(12'h600, 32'h0100_1101, "R10 read via set alias");
    rd(12'h800, 32'h0, "R10 unmapped address");
    // R8 and R4: all ones to word1 -> lines 4,5 get 0x71, lines 6,7 stay 0
    wr(12'h604, 32'hFFFF_FFFF);
    rd(12'h504, 32'h0000_7171, "R8 limit lines read 0, R4 strobe reads 0");
    // R3 clear alias
    wr(12'h704, 32'h0000_FF00);
    rd(12'h704, 32'h0000_0071, "R3 clear line5 byte");
    wr(12'h704, 32'h0000_00FF);
    rd(12'h504, 32'h0, "R3 clear line4 byte");

    // R7 bypass: line2 disabled, line3 not level sensitive, line7 beyond limit
    line_in[2] = 1'b1; line_in[3] = 1'b1; line_in[7] = 1'b1;
    expect_out(2, 2, 1'b0, "R7 line2 before");
    expect_out(3, 2, 1'b1, "R7 line2 disabled follows");
    expect_out(3, 3, 1'b1, "R7 line3 edge sensitive follows");
    expect_out(2, 7, 1'b0, "R7 line7 before");
    expect_out(3, 7, 1'b1, "R7 line7 beyond limit follows");
    drain();

    // R6 R11: line0 window 500 ticks x 2 cycles
    line_in[0] = 1'b1;
    expect_out(995, 0, 1'b0, "R6 line0 holds before window");
    expect_out(1006, 0, 1'b1, "R11 line0 changes after window");
    drain();
    // R6 short excursion rejected
    line_in[0] = 1'b0;
    expect_out(300, 0, 1'b1, "R6 glitch mid");
    repeat (600) @(negedge clk);
    line_in[0] = 1'b1;
    expect_out(700, 0, 1'b1, "R6 glitch rejected");
    drain();

    // R4 restart strobe on line1 (code1 = 1000 ticks)
    line_in[1] = 1'b1;
    expect_out(2100, 1, 1'b0, "R4 past original window");
    expect_out(3490, 1, 1'b0, "R4 restart extends wait");
    expect_out(3515, 1, 1'b1, "R4 change after restart");
    repeat (1500) @(negedge clk);
    wr(12'h600, 32'h0000_0200);
    rd(12'h500, 32'h0100_1101, "R4 strobe reads 0");
    drain();

    // R5 code2 = 16000 ticks on line0
    wr(12'h700, 32'h0000_00FF);
    rd(12'h500, 32'h0100_1100, "R3 clear line0 byte");
    wr(12'h600, 32'h0000_0021);
    rd(12'h500, 32'h0100_1121, "R5 code2 loaded");
    line_in[0] = 1'b0;
    expect_out(31995, 0, 1'b1, "R5 code2 holds");
    expect_out(32006, 0, 1'b0, "R5 code2 window");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule